// File: doc/BRIEF.md
# Quasi-Cyclic Row Alpha Accumulator

This block produces the per-row alpha vectors for a quasi-cyclic LDPC encoder, and also produces the first parity subblock. After a start pulse it walks a lookup table one entry per cycle. Each entry gives three things: a column address, a shift value, and end-of-row and end-of-frame flags. The block uses the column address to read one Z-bit information subblock. It rotates that subblock cyclically by the shift, with the rotation wrapping at the selected expansion factor Z. It then XORs the rotated subblock into a running row accumulator.

When an entry closes a row, the accumulated row result goes out on a write port to an external alpha RAM, and the accumulator clears. Every row result is also folded by XOR into a running first-parity value. That value is presented with a valid flag and a one-cycle done pulse once the frame's last entry has been consumed.

The lookup table and the information store both sit outside the block and answer combinationally in the same cycle. The expansion factor is chosen per frame from four supported sizes.

Top module: `qc_alpha_accum`

## Requirements
- R1: After reset, `busy`, `done`, `p0_valid` and `alpha_we` are 0.
- R2: The rotated subblock for a shift s and factor Z has bit j equal to information bit (j+s) mod Z for j < Z. Information bits at positions Z and above are ignored. Every output vector has zeros in bits Z and above.
- R3: A shift value from Z up to 126 rotates by s mod Z.
- R4: A shift of 127 (all seven bits set) marks an empty entry and leaves the row accumulator unchanged.
- R5: An entry with the row-last flag causes a write one cycle later. The write carries the row's accumulated value at address equal to the row number (counting from 0 in the frame), and the next row starts from zero.
- R6: `p0_data` equals the XOR of all row results of the frame. `p0_valid` rises together with `done` and stays high until the next accepted start, which clears it.
- R7: `done` is a single-cycle pulse. It appears N+1 cycles after the start edge for a frame of N table entries, and `busy` is low when it appears.
- R8: A start pulse while busy is ignored, including any change of `z_sel` that comes with it.
- R9: `tbl_addr` is 0 in the first busy cycle and steps by one every busy cycle. `info_addr` carries the current entry's column.
- R10: `z_sel`, sampled at an accepted start, selects Z: 0→27, 1→54, 2→81, 3→42.
- R11: The frame-last flag also ends the current row, and the final row is written even if its row-last flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| z_sel | input | 2 | Expansion factor select |
| tbl_addr | output | 8 | Table entry index |
| tbl_col | input | 4 | Column address of the entry |
| tbl_shift | input | 7 | Shift of the entry, 127 = empty |
| tbl_row_last | input | 1 | Entry closes its row |
| tbl_frame_last | input | 1 | Entry is the last of the frame |
| info_addr | output | 4 | Information subblock address |
| info_data | input | 81 | Information subblock read data |
| alpha_we | output | 1 | Alpha RAM write strobe |
| alpha_addr | output | 4 | Alpha RAM row address |
| alpha_data | output | 81 | Row result |
| p0_data | output | 81 | First parity subblock |
| p0_valid | output | 1 | First parity is complete |
| done | output | 1 | Frame finished pulse |
| busy | output | 1 | Frame in progress |

## Verification
The case that is hardest to reach from the ports is a shift that wraps at a Z smaller than the word width, combined with a row that is partly or wholly made of empty entries. A wrong wrap point or a skipped entry that leaks into the row only shows up in a few bit positions of one row. To get there, the stimulus fills every information word with random bits above Z. It draws about one shift in ten as the empty marker and one in ten between Z and 126. Directed frames add an all-empty row, a shift of Z-1, and a mid-frame start with a different `z_sel`, and these run under every Z.

// File: rtl/qc_pkg.sv
package qc_pkg;
  localparam int ZMAX  = 81;
  localparam int SHW   = 7;
  localparam int NZ    = 4;
  localparam int ZSW   = $clog2(NZ);
  localparam logic [SHW-1:0] SHIFT_EMPTY = '1;

  typedef logic [ZMAX-1:0] zvec_t;
  typedef enum logic { ST_IDLE, ST_RUN } run_st_t;

  function automatic int z_of(input int sel);
    case (sel)
      0:       return 27;
      1:       return 54;
      2:       return 81;
      default: return 42;
    endcase
  endfunction

  function automatic zvec_t z_mask(input logic [ZSW-1:0] sel);
    zvec_t m;
    for (int j = 0; j < ZMAX; j++) m[j] = (j < z_of(int'(sel)));
    return m;
  endfunction
endpackage

// File: rtl/qc_zrot.sv
module qc_zrot #(
  parameter int ZW  = 81,
  parameter int Z   = 81,
  parameter int SW  = 7
) (
  input  logic [ZW-1:0] din,
  input  logic [SW-1:0] sh,
  output logic [ZW-1:0] dout
);
  logic [SW:0][ZW-1:0] st;

  for (genvar j = 0; j < ZW; j++) begin : g_in
    if (j < Z) begin : g_keep
      assign st[0][j] = din[j];
    end else begin : g_zero
      assign st[0][j] = 1'b0;
    end
  end

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int AMT = (1 << k) % Z;
    for (genvar j = 0; j < ZW; j++) begin : g_bit
      if (j < Z) begin : g_rot
        assign st[k+1][j] = sh[k] ? st[k][(j + AMT) % Z] : st[k][j];
      end else begin : g_pad
        assign st[k+1][j] = 1'b0;
      end
    end
  end

  assign dout = st[SW];
endmodule

// File: rtl/qc_rot_bank.sv
module qc_rot_bank
  import qc_pkg::*;
(
  input  zvec_t              din,
  input  logic [SHW-1:0]     sh,
  input  logic [ZSW-1:0]     zsel,
  output zvec_t              dout
);
  zvec_t outs [NZ];

  for (genvar i = 0; i < NZ; i++) begin : g_z
    qc_zrot #(.ZW(ZMAX), .Z(z_of(i)), .SW(SHW)) u_rot (
      .din  (din),
      .sh   (sh),
      .dout (outs[i])
    );
  end

  assign dout = outs[zsel];
endmodule

// File: rtl/qc_row_fsm.sv
module qc_row_fsm
  import qc_pkg::*;
#(
  parameter int TBL_AW = 8,
  parameter int ROW_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ent_row_last,
  input  logic              ent_frame_last,
  output logic              busy,
  output logic [TBL_AW-1:0] ent_addr,
  output logic [ROW_AW-1:0] row_idx,
  output logic              row_end,
  output logic              frame_end,
  output logic              accept,
  output logic              done
);
  run_st_t           st_q, st_d;
  logic [TBL_AW-1:0] ptr_q, ptr_d;
  logic [ROW_AW-1:0] row_q, row_d;
  logic              done_q, done_d;
  logic              ptr_en, row_en;

  always_comb begin
    busy      = (st_q == ST_RUN);
    accept    = start && (st_q == ST_IDLE);
    row_end   = busy && (ent_row_last || ent_frame_last);
    frame_end = busy && ent_frame_last;

    st_d = st_q;
    if (accept)         st_d = ST_RUN;
    else if (frame_end) st_d = ST_IDLE;

    ptr_en = accept || busy;
    ptr_d  = accept ? '0 : ptr_q + 1'b1;
    row_en = accept || row_end;
    row_d  = accept ? '0 : row_q + 1'b1;
    done_d = frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (row_en) row_q <= row_d;
    end
  end

  assign ent_addr = ptr_q;
  assign row_idx  = row_q;
  assign done     = done_q;

  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (ent_addr == $past(ent_addr) + 1'b1));
  a_r9_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> (ent_addr == '0));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/qc_alpha_accum.sv
module qc_alpha_accum
  import qc_pkg::*;
#(
  parameter int TBL_AW = 8,
  parameter int COL_AW = 4,
  parameter int ROW_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ZSW-1:0]    z_sel,
  output logic [TBL_AW-1:0] tbl_addr,
  input  logic [COL_AW-1:0] tbl_col,
  input  logic [SHW-1:0]    tbl_shift,
  input  logic              tbl_row_last,
  input  logic              tbl_frame_last,
  output logic [COL_AW-1:0] info_addr,
  input  logic [ZMAX-1:0]   info_data,
  output logic              alpha_we,
  output logic [ROW_AW-1:0] alpha_addr,
  output logic [ZMAX-1:0]   alpha_data,
  output logic [ZMAX-1:0]   p0_data,
  output logic              p0_valid,
  output logic              done,
  output logic              busy
);
  logic              accept, row_end, frame_end;
  logic [ROW_AW-1:0] row_idx;
  logic [ZSW-1:0]    zsel_q;
  zvec_t             rot, acc_q, acc_d, acc_nx, p0_q, p0_d;
  zvec_t             wdat_q;
  logic [ROW_AW-1:0] waddr_q;
  logic              we_q, pv_q, pv_d;
  logic              acc_en, p0_en, wr_en, pv_en;
  logic              ent_empty;

  qc_row_fsm #(.TBL_AW(TBL_AW), .ROW_AW(ROW_AW)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .ent_row_last   (tbl_row_last),
    .ent_frame_last (tbl_frame_last),
    .busy           (busy),
    .ent_addr       (tbl_addr),
    .row_idx        (row_idx),
    .row_end        (row_end),
    .frame_end      (frame_end),
    .accept         (accept),
    .done           (done)
  );

  qc_rot_bank u_rot (
    .din  (info_data),
    .sh   (tbl_shift),
    .zsel (zsel_q),
    .dout (rot)
  );

  assign info_addr = tbl_col;

  always_comb begin
    ent_empty = (tbl_shift == SHIFT_EMPTY);
    acc_nx    = ent_empty ? acc_q : (acc_q ^ rot);

    acc_en = accept || busy;
    acc_d  = (accept || row_end) ? '0 : acc_nx;

    p0_en  = accept || row_end;
    p0_d   = accept ? '0 : (p0_q ^ acc_nx);

    wr_en  = row_end;

    pv_en  = accept || frame_end;
    pv_d   = !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zsel_q  <= '0;
      acc_q   <= '0;
      p0_q    <= '0;
      wdat_q  <= '0;
      waddr_q <= '0;
      we_q    <= 1'b0;
      pv_q    <= 1'b0;
    end else begin
      we_q <= wr_en;
      if (accept) zsel_q <= z_sel;
      if (acc_en) acc_q  <= acc_d;
      if (p0_en)  p0_q   <= p0_d;
      if (pv_en)  pv_q   <= pv_d;
      if (wr_en) begin
        wdat_q  <= acc_nx;
        waddr_q <= row_idx;
      end
    end
  end

  assign alpha_we   = we_q;
  assign alpha_addr = waddr_q;
  assign alpha_data = wdat_q;
  assign p0_data    = p0_q;
  assign p0_valid   = pv_q;

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    alpha_we |-> $past(busy));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    alpha_we |-> ((alpha_data & ~z_mask(zsel_q)) == '0));
  a_r6_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> p0_valid);
  a_r6_p0_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_valid && !start) |=> ($stable(p0_data) && p0_valid));
  a_r8_zsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> $stable(zsel_q));
  a_r11_last_writes: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> alpha_we);
endmodule

// File: tb/qc_alpha_accum_test.sv
module qc_alpha_accum_test;
  logic        clk, rst_n, start;
  logic [1:0]  z_sel;
  logic [7:0]  tbl_addr;
  logic [3:0]  tbl_col, info_addr;
  logic [6:0]  tbl_shift;
  logic        tbl_row_last, tbl_frame_last;
  logic [80:0] info_data, alpha_data, p0_data;
  logic        alpha_we, p0_valid, done, busy;
  logic [3:0]  alpha_addr;

  logic [3:0]  tcol [256];
  logic [6:0]  tsh  [256];
  logic        trl  [256];
  logic        tfl  [256];
  logic [80:0] imem [16];

  logic [80:0] cap_d [16];
  logic [3:0]  cap_a [16];
  int          capn, step_cnt, step_err, cycles;
  int          checks, fails;

  logic [80:0] ea [16];
  logic [80:0] ep;
  int          enr, nent;

  assign tbl_col        = tcol[tbl_addr];
  assign tbl_shift      = tsh[tbl_addr];
  assign tbl_row_last   = trl[tbl_addr];
  assign tbl_frame_last = tfl[tbl_addr];
  assign info_data      = imem[info_addr];

  qc_alpha_accum uut (
    .clk(clk), .rst_n(rst_n), .start(start), .z_sel(z_sel),
    .tbl_addr(tbl_addr), .tbl_col(tbl_col), .tbl_shift(tbl_shift),
    .tbl_row_last(tbl_row_last), .tbl_frame_last(tbl_frame_last),
    .info_addr(info_addr), .info_data(info_data),
    .alpha_we(alpha_we), .alpha_addr(alpha_addr), .alpha_data(alpha_data),
    .p0_data(p0_data), .p0_valid(p0_valid), .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (alpha_we && capn < 16) begin
      cap_d[capn] = alpha_data;
      cap_a[capn] = alpha_addr;
      capn++;
    end
    if (busy) begin
      if (tbl_addr != step_cnt[7:0] || info_addr != tcol[tbl_addr]) step_err++;
      step_cnt++;
    end
  end

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic int zl(input int s);
    case (s)
      0: return 27; 1: return 54; 2: return 81; default: return 42;
    endcase
  endfunction

  function automatic logic [80:0] rotf(input logic [80:0] d, input int s, input int z);
    logic [80:0] o = '0;
    for (int j = 0; j < z; j++) o[j] = d[(j + s) % z];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [80:0] act, input logic [80:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < 256; i++) begin
      tcol[i] = 4'($urandom % 16); tsh[i] = 7'($urandom % 127);
      trl[i] = 1'b0; tfl[i] = 1'b0;
    end
  endtask

  task automatic fill_info();
    for (int i = 0; i < 16; i++)
      imem[i] = {17'($urandom), $urandom, $urandom};
  endtask

  task automatic gen_random(input int z);
    int idx = 0;
    int nr = 1 + $urandom % 12;
    clear_tbl();
    for (int r = 0; r < nr; r++) begin
      int ne = 1 + $urandom % 5;
      for (int e = 0; e < ne; e++) begin
        int p = $urandom % 10;
        tcol[idx] = 4'($urandom % 16);
        if (p == 0)      tsh[idx] = 7'd127;
        else if (p == 1) tsh[idx] = 7'(z + $urandom % (127 - z));
        else             tsh[idx] = 7'($urandom % z);
        trl[idx] = (e == ne - 1);
        tfl[idx] = (e == ne - 1) && (r == nr - 1);
        idx++;
      end
    end
  endtask

  task automatic compute(input int z);
    logic [80:0] acc = '0;
    enr = 0; ep = '0; nent = 0;
    for (int i = 0; i < 256; i++) begin
      nent++;
      if (tsh[i] != 7'd127) acc ^= rotf(imem[tcol[i]], int'(tsh[i]), z);
      if (trl[i] || tfl[i]) begin
        ea[enr] = acc; ep ^= acc; enr++; acc = '0;
      end
      if (tfl[i]) break;
    end
  endtask

  task automatic run_frame(input int zs, input bit poke, input string tag);
    int t = 0;
    int z = zl(zs);
    bit seen = 0;
    compute(z);
    @(negedge clk); #1;
    capn = 0; step_cnt = 0; step_err = 0;
    z_sel = 2'(zs); start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    chk(p0_valid == 1'b0, "R6 clear on start", 81'(p0_valid), 81'(0));
    t = 1;
    if (poke) begin
      z_sel = 2'(zs ^ 1); start = 1'b1;
    end
    while (!seen && t < 400) begin
      @(negedge clk); #1;
      start = 1'b0;
      t++;
      if (done) seen = 1;
    end
    chk(seen && t == nent + 1, {"R7 done latency ", tag}, 81'(t), 81'(nent + 1));
    chk(!busy && p0_valid, {"R6 valid with done ", tag}, 81'({busy, p0_valid}), 81'(1));
    chk(p0_data == ep, {"R6 first parity ", tag}, p0_data, ep);
    chk(step_err == 0, {"R9 table stepping ", tag}, 81'(step_err), 81'(0));
    @(negedge clk); #1;
    chk(!done, {"R7 single pulse ", tag}, 81'(done), 81'(0));
    chk(capn == enr, {"R5 write count ", tag}, 81'(capn), 81'(enr));
    for (int r = 0; r < enr && r < 16; r++) begin
      if (cap_a[r] != 4'(r) || cap_d[r] != ea[r]) begin
        chk(0, {"R5 R2 row result ", tag}, cap_d[r], ea[r]);
      end
    end
    chk(1, "R2 rows", '0, '0);
    repeat (3) @(negedge clk);
    #1;
    chk(p0_valid && p0_data == ep, {"R6 hold ", tag}, p0_data, ep);
  endtask

  initial begin
    void'($urandom(32'h1c3a_5eed));
    checks = 0; fails = 0; cycles = 0; capn = 0; step_cnt = 0; step_err = 0;
    rst_n = 1'b0; start = 1'b0; z_sel = 2'd0;
    clear_tbl(); fill_info();
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !p0_valid && !alpha_we, "R1 reset state",
        81'({busy, done, p0_valid, alpha_we}), 81'(0));
    rst_n = 1'b1;
    @(negedge clk);

    for (int zs = 0; zs < 4; zs++) begin
      int z = zl(zs);
      // R2 R3: single entry, shift Z-1 then shift at Z+3 wrapping
      clear_tbl(); fill_info();
      tcol[0] = 4'd5; tsh[0] = 7'(z - 1); trl[0] = 1'b1;
      tcol[1] = 4'd9; tsh[1] = 7'(z + 3); trl[1] = 1'b1; tfl[1] = 1'b1;
      run_frame(zs, 0, "R2 R3 R10 wrap");
      // R4: all-empty middle row, R11: last row without row-last flag
      clear_tbl();
      tcol[0] = 4'd1; tsh[0] = 7'd0;   trl[0] = 1'b1;
      tcol[1] = 4'd2; tsh[1] = 7'd127;
      tcol[2] = 4'd3; tsh[2] = 7'd127; trl[2] = 1'b1;
      tcol[3] = 4'd4; tsh[3] = 7'd1;
      tcol[4] = 4'd4; tsh[4] = 7'd127;
      tcol[5] = 4'd6; tsh[5] = 7'(z / 2); tfl[5] = 1'b1;
      run_frame(zs, 0, "R4 R11 empty");
      chk(capn == 3 && cap_d[1] == '0, "R4 empty row is zero", cap_d[1], '0);
    end

    for (int n = 0; n < 24; n++) begin
      int zs = $urandom % 4;
      fill_info();
      gen_random(zl(zs));
      run_frame(zs, (n % 4) == 3, (n % 4) == 3 ? "R8 start while busy" : "R10 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule